// File: doc/BRIEF.md
# Banked RAM-Disk Port Controller

This block sits on a simple CPU I/O bus and presents a banked byte store through two adjacent ports. The CPU builds a 22-bit pointer by writing bytes to the address port. Each byte is shifted in at the bottom of the pointer. The CPU then moves data through the data port one byte at a time. Every data access, read or write, advances the pointer by one. A block transfer therefore needs a single address load followed by back-to-back data accesses.

The top three pointer bits pick one of eight storage units. The low bits index a byte within the chosen unit. Each unit has an input that marks it present and an input that locks it against writes.

- An absent unit reads as all ones.
- A write to an absent unit or to a locked unit is discarded without any error indication, but the pointer still advances.

The depth of each unit is a parameter, kept small for simulation. Read data is combinational: it reflects the byte at the current pointer while the data port is selected, and the pointer moves at the clock edge that ends the access.

Top module: `rdisk_port_ctrl`

## Requirements
- R1: After synchronous active-low reset the pointer is 0 and every byte of every unit holds 0x00.
- R2: A write strobe with `port_sel`=1 (address port) loads the pointer with {old pointer bits 13:0, written byte}, so only the last 22 bits shifted in are kept.
- R3: Any single read or write strobe with `port_sel`=0 (data port) increments the pointer by one at the clock edge, wrapping from 0x3FFFFF to 0; a carry out of the offset moves into the next unit.
- R4: Pointer bits 21:19 select the unit and bits OFS_W-1:0 select the byte; bits 18:OFS_W are ignored for indexing.
- R5: With `port_sel`=0, `rdata` is the stored byte when the selected unit is present and 0xFF when it is absent.
- R6: A data-port write to a present, unlocked unit stores the byte at the current offset.
- R7: A data-port write to a locked or absent unit leaves all storage unchanged, and the pointer still increments.
- R8: With `port_sel`=1, `rdata` is 0xFF, and an address-port read leaves the pointer and storage unchanged.
- R9: Read and write strobes asserted together are an illegal cycle. Such a cycle changes neither the pointer nor storage.
- R10: Back-to-back data-port reads return bytes from consecutive offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_sel | input | 1 | Lowest I/O address bit: 0 = data port, 1 = address port |
| rd_stb | input | 1 | Single-cycle read strobe |
| wr_stb | input | 1 | Single-cycle write strobe |
| wdata | input | 8 | Write data from the CPU |
| rdata | output | 8 | Read data to the CPU (combinational) |
| unit_present | input | 8 | One bit per unit, 1 = unit present |
| unit_lock | input | 8 | One bit per unit, 1 = unit write-locked |

## Verification
The assertions assume the following about the inputs:

- Strobes are sampled once per clock edge, one edge per access.
- `port_sel`, `wdata` and the presence mask are stable across the cycle in which a strobe is high.
- The combinational read-data check relies on `unit_present` being settled before `rdata` is compared.

The stimulus keeps within these assumptions by changing every input only on the falling clock edge. It holds each strobe for exactly one rising edge and returns to idle afterwards. The only cycle with both strobes high is the deliberate test of the illegal combination.

// File: rtl/rdisk_pkg.sv
// Shared constants for the banked RAM-disk port controller.
// Assumes a fixed 22-bit pointer split into a 3-bit unit field and a byte offset.
package rdisk_pkg;
    localparam int PTR_W     = 22;
    localparam int UNIT_W    = 3;
    localparam int NUM_UNITS = 1 << UNIT_W;
    localparam int BYTE_W    = 8;
    localparam int UNIT_LSB  = PTR_W - UNIT_W;

    typedef enum logic {
        PORT_DATA = 1'b0,
        PORT_ADDR = 1'b1
    } port_e;
endpackage

// File: rtl/rdisk_ptr.sv
// Pointer register: shifts in address bytes and steps by one per data access.
// Assumes load and step are never asserted together (decoded by the top).
module rdisk_ptr
    import rdisk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [BYTE_W-1:0] din,
    output logic [PTR_W-1:0]  ptr
);
    // Update the pointer: reset, byte shift-in, or modulo-2^22 increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= {ptr[PTR_W-BYTE_W-1:0], din};
        end else if (step) begin
            ptr <= ptr + 1'b1;
        end
    end
endmodule

// File: rtl/rdisk_banks.sv
// Storage units: one small byte array per unit, written only when present and unlocked.
// Read data is combinational; an absent unit yields all ones.
module rdisk_banks
    import rdisk_pkg::*;
#(
    parameter int OFS_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [UNIT_W-1:0]    unit_sel,
    input  logic [OFS_W-1:0]     ofs,
    input  logic [BYTE_W-1:0]    wdata,
    input  logic [NUM_UNITS-1:0] present,
    input  logic [NUM_UNITS-1:0] lock,
    output logic [BYTE_W-1:0]    rdata
);
    localparam int DEPTH = 1 << OFS_W;

    logic [BYTE_W-1:0] unit_rd [NUM_UNITS];

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        logic [BYTE_W-1:0] cells [DEPTH];
        logic              wr_here;

        assign wr_here = we && (unit_sel == UNIT_W'(u)) && present[u] && !lock[u];

        // Zero-fill on reset, otherwise accept a permitted write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) begin
                    cells[i] <= '0;
                end
            end else if (wr_here) begin
                cells[ofs] <= wdata;
            end
        end

        assign unit_rd[u] = cells[ofs];
    end

    // Select the addressed unit's byte, or all ones when it is absent.
    always_comb begin
        rdata = present[unit_sel] ? unit_rd[unit_sel] : '1;
    end
endmodule

// File: rtl/rdisk_port_ctrl.sv
// Top of the banked RAM-disk port controller: decodes the two-port window,
// drives the pointer and the storage units, and forms the read data.
// Assumes strobes last one clock; both strobes together are ignored.
module rdisk_port_ctrl
    import rdisk_pkg::*;
#(
    parameter int OFS_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 port_sel,
    input  logic                 rd_stb,
    input  logic                 wr_stb,
    input  logic [BYTE_W-1:0]    wdata,
    output logic [BYTE_W-1:0]    rdata,
    input  logic [NUM_UNITS-1:0] unit_present,
    input  logic [NUM_UNITS-1:0] unit_lock
);
    logic [PTR_W-1:0]  cur_ptr;
    logic              one_stb;
    logic              ptr_load;
    logic              ptr_step;
    logic              mem_we;
    logic [BYTE_W-1:0] bank_rd;
    logic              unused_hi;

    // Decode the strobes; a cycle with both strobes high does nothing.
    always_comb begin
        one_stb  = rd_stb ^ wr_stb;
        ptr_load = one_stb && wr_stb && (port_sel == PORT_ADDR);
        ptr_step = one_stb && (port_sel == PORT_DATA);
        mem_we   = one_stb && wr_stb && (port_sel == PORT_DATA);
    end

    assign unused_hi = ^cur_ptr[UNIT_LSB-1:OFS_W];

    rdisk_ptr u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (ptr_load),
        .step  (ptr_step),
        .din   (wdata),
        .ptr   (cur_ptr)
    );

    rdisk_banks #(.OFS_W(OFS_W)) u_banks (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (mem_we),
        .unit_sel (cur_ptr[PTR_W-1:UNIT_LSB]),
        .ofs      (cur_ptr[OFS_W-1:0]),
        .wdata    (wdata),
        .present  (unit_present),
        .lock     (unit_lock),
        .rdata    (bank_rd)
    );

    // The address port always reads as all ones.
    always_comb begin
        rdata = (port_sel == PORT_ADDR) ? '1 : bank_rd;
    end
endmodule

// File: rtl/rdisk_checker.sv
// Property checker for rdisk_port_ctrl, bound to every instance of the top.
module rdisk_checker
    import rdisk_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 port_sel,
    input logic                 rd_stb,
    input logic                 wr_stb,
    input logic [BYTE_W-1:0]    wdata,
    input logic [BYTE_W-1:0]    rdata,
    input logic [NUM_UNITS-1:0] unit_present,
    input logic [PTR_W-1:0]     ptr
);
    AST_PTR_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !rd_stb && port_sel) |=> ptr == {$past(ptr[PTR_W-BYTE_W-1:0]), $past(wdata)}); // R2
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_stb ^ wr_stb) && !port_sel) |=> ptr == PTR_W'($past(ptr) + 22'd1)); // R3
    AST_ADDR_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !wr_stb && port_sel) |=> $stable(ptr)); // R8
    AST_BOTH_STB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && wr_stb) |=> $stable(ptr)); // R9
    AST_ABSENT_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (!port_sel && !unit_present[ptr[PTR_W-1:UNIT_LSB]]) |-> rdata == 8'hFF); // R5
    AST_ADDR_PORT_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        port_sel |-> rdata == 8'hFF); // R8
endmodule

bind rdisk_port_ctrl rdisk_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .port_sel     (port_sel),
    .rd_stb       (rd_stb),
    .wr_stb       (wr_stb),
    .wdata        (wdata),
    .rdata        (rdata),
    .unit_present (unit_present),
    .ptr          (cur_ptr)
);

// File: tb/sim_rdisk_port_ctrl.sv
module sim_rdisk_port_ctrl;
    localparam int PERIOD = 10;
    localparam int OFS_W  = 4;
    localparam int DEPTH  = 1 << OFS_W;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       port_sel = 1'b0;
    logic       rd_stb = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [7:0] unit_present = 8'h01;
    logic [7:0] unit_lock = 8'h00;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0]  bm [8*DEPTH];
    logic [21:0] baddr = '0;
    logic [7:0]  got;

    always #(PERIOD/2) clk = ~clk;

    rdisk_port_ctrl #(.OFS_W(OFS_W)) u0 (
        .clk(clk), .rst_n(rst_n), .port_sel(port_sel), .rd_stb(rd_stb),
        .wr_stb(wr_stb), .wdata(wdata), .rdata(rdata),
        .unit_present(unit_present), .unit_lock(unit_lock)
    );

    function automatic int idx(input logic [21:0] a);
        return int'(a[21:19]) * DEPTH + int'(a[OFS_W-1:0]);
    endfunction

    function automatic logic [7:0] pat(input int u, input int o, input int k);
        return 8'((u * 37 + o * 5 + k * 11 + 1) & 255);
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h (addr %06h)", tag, act, exp, baddr);
        end
    endtask

    // One bus cycle: drive at falling edge, sample read data, clock, return to idle.
    task automatic cyc(input logic ps, input logic rd, input logic wr, input logic [7:0] d);
        @(negedge clk);
        port_sel = ps; rd_stb = rd; wr_stb = wr; wdata = d;
        #2 got = rdata;
        @(posedge clk);
        #1 rd_stb = 1'b0; wr_stb = 1'b0; port_sel = 1'b0;
    endtask

    task automatic put_byte(input logic [7:0] b);
        cyc(1'b1, 1'b0, 1'b1, b);
        baddr = {baddr[13:0], b};
    endtask

    task automatic load(input logic [21:0] a);
        put_byte({2'b00, a[21:16]});
        put_byte(a[15:8]);
        put_byte(a[7:0]);
    endtask

    task automatic data_rd(input string tag);
        logic [7:0] exp;
        exp = unit_present[baddr[21:19]] ? bm[idx(baddr)] : 8'hFF;
        cyc(1'b0, 1'b1, 1'b0, 8'h00);
        check(tag, got, exp);
        baddr = baddr + 22'd1;
    endtask

    task automatic data_wr(input logic [7:0] d);
        if (unit_present[baddr[21:19]] && !unit_lock[baddr[21:19]]) bm[idx(baddr)] = d;
        cyc(1'b0, 1'b0, 1'b1, d);
        baddr = baddr + 22'd1;
    endtask

    function automatic logic [21:0] base_of(input int u);
        return 22'(u) << 19;
    endfunction

    initial begin
        #(PERIOD * 100000);
        n_bad++; n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8*DEPTH; i++) bm[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2 check("R1 reset byte at pointer 0", rdata, 8'h00);

        // R1: every byte of every unit is zero after reset
        unit_present = 8'hFF;
        for (int u = 0; u < 8; u++) begin
            load(base_of(u));
            for (int o = 0; o < DEPTH; o++) data_rd("R1 zero fill");
        end

        // R6 R10: fill every unit, then read back sequentially
        for (int u = 0; u < 8; u++) begin
            load(base_of(u));
            for (int o = 0; o < DEPTH; o++) data_wr(pat(u, o, 0));
        end
        for (int u = 0; u < 8; u++) begin
            load(base_of(u));
            for (int o = 0; o < DEPTH; o++) data_rd("R10 R6 sequential readback");
        end

        // R7: locked units 2 and 5 keep their contents
        unit_lock = 8'b0010_0100;
        for (int u = 0; u < 8; u++) begin
            load(base_of(u));
            for (int o = 0; o < DEPTH; o++) data_wr(pat(u, o, 1));
        end
        unit_lock = 8'h00;
        for (int u = 0; u < 8; u++) begin
            load(base_of(u));
            for (int o = 0; o < DEPTH; o++) data_rd("R7 lock readback");
        end

        // R5 R7: absent unit 3 reads all ones and drops writes
        unit_present = 8'b1111_0111;
        load(base_of(3));
        for (int o = 0; o < DEPTH; o++) data_rd("R5 absent unit");
        load(base_of(3));
        for (int o = 0; o < DEPTH; o++) data_wr(8'hC3);
        data_rd("R7 pointer advanced past absent writes");
        unit_present = 8'hFF;
        load(base_of(3));
        for (int o = 0; o < DEPTH; o++) data_rd("R7 absent storage kept");

        // R8: address port reads all ones and leaves the pointer alone
        load(22'h1A0006);
        cyc(1'b1, 1'b1, 1'b0, 8'h00);
        check("R8 address port read", got, 8'hFF);
        data_rd("R8 pointer unchanged after address read");

        // R2: a fourth byte pushes the oldest one out
        put_byte(8'h3F); put_byte(8'h12); put_byte(8'h34); put_byte(8'h09);
        data_rd("R2 shift keeps low 22 bits");

        // R3: carry into the next unit and wrap at the top
        load(22'h07FFFF);
        data_rd("R3 last byte of unit 0");
        data_rd("R3 carry into unit 1");
        load(22'h3FFFFF);
        data_rd("R3 top of space");
        check("R3 wrapped model pointer", {2'b00, baddr[21:16]}, 8'h00);
        data_rd("R3 wrap to pointer 0");

        // R4: middle offset bits do not affect indexing
        load(22'h0ABCD3);
        data_rd("R4 high offset bits ignored");
        load(22'h2FFFF5);
        data_rd("R4 unit 5 alias");

        // R9: both strobes at once neither write nor move the pointer
        load(22'h300004);
        cyc(1'b0, 1'b1, 1'b1, 8'hEE);
        data_rd("R9 both strobes ignored");

        // R5: present unit with a single-unit mask
        unit_present = 8'h01;
        load(22'h000002);
        data_rd("R5 present unit 0");
        load(22'h100002);
        data_rd("R5 absent unit 2");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule